// File: doc/BRIEF.md
# Type-0 Function Configuration Header

This block is the register file behind the 64-byte standard header of a single bus function. A host reaches it through a small request port. Each request carries a byte offset, an access width of 1, 2 or 4 bytes, a write enable and write data. The response is registered: `ack_o`, `rdata_o` and `err_o` appear one cycle after the request strobe.

Most identification fields are constants taken from parameters. Command, Status, Cache Line Size, Latency Timer, Interrupt Line and the expansion ROM base are held in flops and reload their parameter values at reset. Up to six base address slots each have a region size parameter. Writing all ones to a slot is a sizing probe and returns the inverted size mask. The low type bits of a slot are never overwritten. A slot flagged as fixed legacy I/O ignores writes and always decodes to its parameter address.

For each slot the block drives the decoded base address and a valid flag to the address decoder downstream. Firmware enumerates the function by probing each slot, reading the mask back and then writing the assigned base.

Top module: `cfg_hdr_regs`

## Requirements
- R1: A read returns `size_i` bytes starting at `off_i`, packed little-endian: the byte at `off_i` lands in `rdata_o[7:0]` and unused upper bytes are zero. The header layout is: vendor 0x00 (16 bits), device 0x02, command 0x04, status 0x06, revision 0x08, programming interface 0x09, subclass 0x0A, class 0x0B, cache line 0x0C, latency timer 0x0D, header type 0x0E, self-test 0x0F, base slots 0x10 + 4*n, card info 0x28, subsystem vendor 0x2C, subsystem 0x2E, ROM base 0x30, zero 0x34 to 0x3B, interrupt line 0x3C, interrupt pin 0x3D, min grant 0x3E, max latency 0x3F. After reset every field reads its parameter value.
- R2: A 4-byte write of 0xFFFFFFFF to a programmable slot stores ~(size-1) above the type bits. A slot of size 0 then reads 0 above its type bits. A nonzero size that is not a power of two stops elaboration.
- R3: A slot's type bits keep their old value on every write. The type field is bits [1:0] when the old bit 0 is 1 (I/O), and bits [3:0] otherwise (memory). All bits above the field take the new value.
- R4: A slot flagged as legacy reads as zero and ignores writes. Its base output is its initial parameter value, and it is valid when that value is nonzero.
- R5: 1-byte writes to 0x3C, 0x0C and 0x0D update Interrupt Line, Cache Line Size and Latency Timer. 1-byte writes to 0x08, 0x3D, 0x3E and 0x3F change nothing and raise no error.
- R6: A 2-byte write at 0x04 loads all 16 Command bits, and at 0x06 all 16 Status bits. A 2-byte write at 0x0C loads only Cache Line Size from `wdata_i[7:0]`; Latency Timer is kept.
- R7: A 4-byte write at 0x04 loads Command from `wdata_i[15:0]` and leaves Status unchanged.
- R8: A 4-byte write of 0xFFFFFFFE to 0x30 makes the ROM base read 0xFFFFFFFF. Any other 4-byte value written there is stored as written.
- R9: `err_o` is raised with the ack, and `rdata_o` is zero, for any of these cases: a width other than 1, 2 or 4; an access that extends past byte 0x3F; a write at any width/offset pair not listed in R2 to R8. Such accesses change no state.
- R10: For a programmable slot, `bar_base_o` is its stored value with the type bits cleared. The slot's `bar_valid_o` bit is 1 exactly when that base is nonzero.
- R11: `ack_o` is high for exactly the one cycle after each cycle in which `req_i` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one access per high cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 8 | Byte offset into the header |
| size_i | input | 3 | Access width in bytes (1, 2 or 4) |
| wdata_i | input | 32 | Write data, byte at `off_i` in bits [7:0] |
| ack_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | 32 | Read data, zero for writes and errors |
| err_o | output | 1 | Access refused, valid with `ack_o` |
| bar_base_o | output | 32*BAR_COUNT | Decoded base address per slot, slot n in bits [32n+31:32n] |
| bar_valid_o | output | BAR_COUNT | Slot n decodes a nonzero base |

## Verification
The bench probes one memory slot, one I/O slot, one prefetchable slot, one zero-size slot and one legacy slot.
- A design that masked with the new value's bit 0 instead of the old one, or used one mask width for both space types, would corrupt the type bits read back after a probe.
- A design that decoded the ROM probe as a plain store would read back 0xFFFFFFFE.
- Width-dependent writes are checked at the ports. A 2-byte write at 0x0C must leave Latency Timer intact, and ignored 1-byte writes must leave neighbouring bytes intact; a write lane decoded too wide would spill into them.
- Straddling reads, unaligned slot writes and odd widths must raise the error flag and zero data, with no state disturbed.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int unsigned HDR_BYTES = 64;
    localparam int unsigned MAX_BARS  = 6;

    // header byte offsets (fixed by the register layout software decodes)
    localparam logic [7:0] OFS_VENDOR = 8'h00;
    localparam logic [7:0] OFS_DEVICE = 8'h02;
    localparam logic [7:0] OFS_CMD    = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h06;
    localparam logic [7:0] OFS_REV    = 8'h08;
    localparam logic [7:0] OFS_PROGIF = 8'h09;
    localparam logic [7:0] OFS_SUBCLS = 8'h0A;
    localparam logic [7:0] OFS_CLASS  = 8'h0B;
    localparam logic [7:0] OFS_CLS    = 8'h0C;
    localparam logic [7:0] OFS_LAT    = 8'h0D;
    localparam logic [7:0] OFS_HDR    = 8'h0E;
    localparam logic [7:0] OFS_BIST   = 8'h0F;
    localparam logic [7:0] OFS_BAR0   = 8'h10;
    localparam logic [7:0] OFS_CIS    = 8'h28;
    localparam logic [7:0] OFS_SSVID  = 8'h2C;
    localparam logic [7:0] OFS_SSID   = 8'h2E;
    localparam logic [7:0] OFS_ROM    = 8'h30;
    localparam logic [7:0] OFS_ILINE  = 8'h3C;
    localparam logic [7:0] OFS_IPIN   = 8'h3D;
    localparam logic [7:0] OFS_MGNT   = 8'h3E;
    localparam logic [7:0] OFS_MLAT   = 8'h3F;

    localparam logic [31:0] IO_TYPE_BITS  = 32'h0000_0003;
    localparam logic [31:0] MEM_TYPE_BITS = 32'h0000_000F;
    localparam logic [31:0] ROM_PROBE_VAL = 32'hFFFF_FFFE;

    typedef enum logic [3:0] {
        WR_NONE,
        WR_IGNORE,
        WR_ILINE,
        WR_CLS,
        WR_LAT,
        WR_CMD,
        WR_STAT,
        WR_BAR,
        WR_ROM
    } wr_kind_e;

    typedef struct packed {
        logic     bad;
        wr_kind_e kind;
        logic [2:0] bar_sel;
    } acc_dec_t;

    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] stat;
        logic [7:0]  cls;
        logic [7:0]  lat;
        logic [7:0]  iline;
        logic [31:0] rom;
        logic        ack;
        logic        err;
        logic [31:0] rdata;
    } hdr_state_t;

    function automatic logic [31:0] type_bits(input logic [31:0] v);
        return v[0] ? IO_TYPE_BITS : MEM_TYPE_BITS;
    endfunction

    function automatic logic [31:0] probe_mask(input logic [31:0] size);
        return ~(size - 32'd1);
    endfunction

    function automatic logic is_pow2_or_zero(input logic [31:0] v);
        return (v & (v - 32'd1)) == 32'd0;
    endfunction

endpackage

// File: rtl/cfg_access_dec.sv
module cfg_access_dec
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned BAR_COUNT = 6
) (
    input  logic [7:0] off_i,
    input  logic [2:0] size_i,
    input  logic       we_i,
    output acc_dec_t   dec_o
);

    logic [8:0] end_ofs;
    logic       size_ok;
    logic [7:0] bar_rel;

    always_comb begin
        dec_o   = '{bad: 1'b0, kind: WR_NONE, bar_sel: 3'd0};
        size_ok = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
        end_ofs = {1'b0, off_i} + {6'd0, size_i};
        bar_rel = off_i - OFS_BAR0;

        if (!size_ok || (end_ofs > 9'(HDR_BYTES))) begin
            dec_o.bad = 1'b1;
        end else if (we_i) begin
            case (size_i)
                3'd1: begin
                    case (off_i)
                        OFS_ILINE: dec_o.kind = WR_ILINE;
                        OFS_CLS:   dec_o.kind = WR_CLS;
                        OFS_LAT:   dec_o.kind = WR_LAT;
                        OFS_REV, OFS_IPIN, OFS_MGNT, OFS_MLAT:
                                   dec_o.kind = WR_IGNORE;
                        default:   dec_o.bad  = 1'b1;
                    endcase
                end
                3'd2: begin
                    case (off_i)
                        OFS_CMD:  dec_o.kind = WR_CMD;
                        OFS_STAT: dec_o.kind = WR_STAT;
                        OFS_CLS:  dec_o.kind = WR_CLS;
                        default:  dec_o.bad  = 1'b1;
                    endcase
                end
                default: begin
                    if ((off_i >= OFS_BAR0) && (bar_rel[1:0] == 2'b00) &&
                        (bar_rel[7:2] < 6'(BAR_COUNT))) begin
                        dec_o.kind    = WR_BAR;
                        dec_o.bar_sel = bar_rel[4:2];
                    end else if (off_i == OFS_ROM) begin
                        dec_o.kind = WR_ROM;
                    end else if (off_i == OFS_CMD) begin
                        dec_o.kind = WR_CMD;
                    end else begin
                        dec_o.bad = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] SIZE   = 32'd0,
    parameter logic [31:0] INIT   = 32'd0,
    parameter bit          LEGACY = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rd_val_o,
    output logic [31:0] base_o,
    output logic        valid_o
);

    if (!is_pow2_or_zero(SIZE)) begin : g_bad_size
        $error("cfg_bar_slot: region size must be zero or a power of two");
    end

    logic [31:0] bar_d, bar_q;
    logic [31:0] wr_val;
    logic [31:0] keep_bits;

    always_comb begin
        keep_bits = type_bits(bar_q);
        wr_val    = (wdata_i == 32'hFFFF_FFFF) ? probe_mask(SIZE) : wdata_i;
        bar_d     = bar_q;
        if (wr_en_i && !LEGACY) begin
            bar_d = (wr_val & ~keep_bits) | (bar_q & keep_bits);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bar_q <= LEGACY ? 32'd0 : INIT;
        end else begin
            bar_q <= bar_d;
        end
    end

    assign rd_val_o = bar_q;

    if (LEGACY) begin : g_fixed
        assign base_o  = INIT;
        assign valid_o = (INIT != 32'd0);
    end else begin : g_prog
        assign base_o  = bar_q & ~type_bits(bar_q);
        assign valid_o = (base_o != 32'd0);
    end

    AST_BAR_TYPE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (((bar_q ^ $past(bar_q)) & type_bits($past(bar_q))) == 32'd0)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(bar_q)); // R10

    AST_LEGACY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (!LEGACY || (rd_val_o == 32'd0))); // R4

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned BAR_COUNT  = 6,
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'hBEEF,
    parameter logic [15:0] CMD_INIT   = 16'h0000,
    parameter logic [15:0] STAT_INIT  = 16'h0010,
    parameter logic [7:0]  REV_ID     = 8'h02,
    parameter logic [7:0]  PROG_IF    = 8'h00,
    parameter logic [7:0]  SUB_CLASS  = 8'h80,
    parameter logic [7:0]  BASE_CLASS = 8'h02,
    parameter logic [7:0]  CLS_INIT   = 8'h00,
    parameter logic [7:0]  LAT_INIT   = 8'h00,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [7:0]  BIST_INIT  = 8'h00,
    parameter logic [BAR_COUNT*32-1:0] BAR_INIT =
        {32'hC000_0000, 32'h0000_0000, 32'h0000_03F8,
         32'h0000_0008, 32'h0000_0001, 32'h0000_0000},
    parameter logic [BAR_COUNT*32-1:0] BAR_SIZE =
        {32'h0000_1000, 32'h0000_0000, 32'h0000_0008,
         32'h0010_0000, 32'h0000_0100, 32'h0000_1000},
    parameter logic [BAR_COUNT-1:0] BAR_LEGACY = 6'b001000,
    parameter logic [31:0] CIS_PTR    = 32'h0000_0000,
    parameter logic [15:0] SUBSYS_VID = 16'h1111,
    parameter logic [15:0] SUBSYS_ID  = 16'h2222,
    parameter logic [31:0] ROM_INIT   = 32'h0000_0000,
    parameter logic [7:0]  ILINE_INIT = 8'h0B,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [7:0]  MIN_GNT    = 8'h04,
    parameter logic [7:0]  MAX_LAT    = 8'h08
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    we_i,
    input  logic [7:0]              off_i,
    input  logic [2:0]              size_i,
    input  logic [31:0]             wdata_i,
    output logic                    ack_o,
    output logic [31:0]             rdata_o,
    output logic                    err_o,
    output logic [BAR_COUNT*32-1:0] bar_base_o,
    output logic [BAR_COUNT-1:0]    bar_valid_o
);

    localparam int unsigned IMG_BITS = HDR_BYTES * 8;

    if ((BAR_COUNT == 0) || (BAR_COUNT > MAX_BARS)) begin : g_bad_count
        $error("cfg_hdr_regs: BAR_COUNT must be 1 to 6");
    end

    localparam hdr_state_t ST_RESET = '{
        cmd:   CMD_INIT,
        stat:  STAT_INIT,
        cls:   CLS_INIT,
        lat:   LAT_INIT,
        iline: ILINE_INIT,
        rom:   ROM_INIT,
        ack:   1'b0,
        err:   1'b0,
        rdata: 32'd0
    };

    hdr_state_t             st_d, st_q;
    acc_dec_t               dec;
    logic [BAR_COUNT-1:0]   bar_wr;
    logic [BAR_COUNT*32-1:0] bar_rd;
    logic [IMG_BITS-1:0]    img;
    logic [31:0]            rd_word;
    logic [5:0]             byte_idx;

    // ---------------- access decode ----------------
    cfg_access_dec #(
        .BAR_COUNT (BAR_COUNT)
    ) u_dec (
        .off_i  (off_i),
        .size_i (size_i),
        .we_i   (we_i),
        .dec_o  (dec)
    );

    // ---------------- base address slots ----------------
    for (genvar b = 0; b < BAR_COUNT; b++) begin : g_bar
        cfg_bar_slot #(
            .SIZE   (BAR_SIZE[b*32 +: 32]),
            .INIT   (BAR_INIT[b*32 +: 32]),
            .LEGACY (BAR_LEGACY[b])
        ) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wr_en_i  (bar_wr[b]),
            .wdata_i  (wdata_i),
            .rd_val_o (bar_rd[b*32 +: 32]),
            .base_o   (bar_base_o[b*32 +: 32]),
            .valid_o  (bar_valid_o[b])
        );
    end

    // ---------------- header image, little-endian ----------------
    always_comb begin
        img = '0;
        img[8*OFS_VENDOR +: 16] = VENDOR_ID;
        img[8*OFS_DEVICE +: 16] = DEVICE_ID;
        img[8*OFS_CMD    +: 16] = st_q.cmd;
        img[8*OFS_STAT   +: 16] = st_q.stat;
        img[8*OFS_REV    +: 8]  = REV_ID;
        img[8*OFS_PROGIF +: 8]  = PROG_IF;
        img[8*OFS_SUBCLS +: 8]  = SUB_CLASS;
        img[8*OFS_CLASS  +: 8]  = BASE_CLASS;
        img[8*OFS_CLS    +: 8]  = st_q.cls;
        img[8*OFS_LAT    +: 8]  = st_q.lat;
        img[8*OFS_HDR    +: 8]  = HDR_TYPE;
        img[8*OFS_BIST   +: 8]  = BIST_INIT;
        for (int b = 0; b < BAR_COUNT; b++) begin
            img[8*OFS_BAR0 + 32*b +: 32] = bar_rd[b*32 +: 32];
        end
        img[8*OFS_CIS    +: 32] = CIS_PTR;
        img[8*OFS_SSVID  +: 16] = SUBSYS_VID;
        img[8*OFS_SSID   +: 16] = SUBSYS_ID;
        img[8*OFS_ROM    +: 32] = st_q.rom;
        img[8*OFS_ILINE  +: 8]  = st_q.iline;
        img[8*OFS_IPIN   +: 8]  = INT_PIN;
        img[8*OFS_MGNT   +: 8]  = MIN_GNT;
        img[8*OFS_MLAT   +: 8]  = MAX_LAT;
    end

    // byte lanes of the read word
    always_comb begin
        rd_word  = '0;
        byte_idx = '0;
        for (int k = 0; k < 4; k++) begin
            byte_idx = off_i[5:0] + 6'(k);
            if (k < int'(size_i)) begin
                rd_word[k*8 +: 8] = img[8*int'(byte_idx) +: 8];
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d       = st_q;
        st_d.ack   = req_i;
        st_d.err   = req_i && dec.bad;
        st_d.rdata = '0;
        bar_wr     = '0;
        if (req_i && !dec.bad) begin
            if (!we_i) begin
                st_d.rdata = rd_word;
            end else begin
                case (dec.kind)
                    WR_ILINE: st_d.iline = wdata_i[7:0];
                    WR_CLS:   st_d.cls   = wdata_i[7:0];
                    WR_LAT:   st_d.lat   = wdata_i[7:0];
                    WR_CMD:   st_d.cmd   = wdata_i[15:0];
                    WR_STAT:  st_d.stat  = wdata_i[15:0];
                    WR_ROM:   st_d.rom   = (wdata_i == ROM_PROBE_VAL) ?
                                           32'hFFFF_FFFF : wdata_i;
                    WR_BAR: begin
                        for (int b = 0; b < BAR_COUNT; b++) begin
                            bar_wr[b] = (dec.bar_sel == 3'(b));
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o   = st_q.ack;
    assign err_o   = st_q.err;
    assign rdata_o = st_q.rdata;

    // ---------------- assertions ----------------
    AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> ack_o); // R11

    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !ack_o); // R11

    AST_ERR_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && dec.bad) |=> (err_o && ack_o)); // R9

    AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (rdata_o == 32'd0)); // R9

    AST_ERR_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && dec.bad) |=> ($stable({st_q.cmd, st_q.stat, st_q.cls,
                                         st_q.lat, st_q.iline, st_q.rom})
                                && $stable(bar_rd))); // R9

    AST_IGNORED_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && (dec.kind == WR_IGNORE)) |=>
            $stable({st_q.cmd, st_q.stat, st_q.cls, st_q.lat, st_q.iline, st_q.rom})); // R5

    AST_ROM_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && (dec.kind == WR_ROM) && (wdata_i == ROM_PROBE_VAL)) |=>
            (st_q.rom == 32'hFFFF_FFFF)); // R8

endmodule

// File: tb/cfg_hdr_regs_bench.sv
module cfg_hdr_regs_bench;

    localparam int NB = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [7:0]        off = '0;
    logic [2:0]        size = '0;
    logic [31:0]       wdata = '0;
    logic              ack;
    logic [31:0]       rdata;
    logic              err;
    logic [NB*32-1:0]  bar_base;
    logic [NB-1:0]     bar_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] got_rd;
    logic        got_err;
    logic        got_ack;

    always #10 clk = ~clk;

    cfg_hdr_regs u_cfg_hdr_regs (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .we_i        (we),
        .off_i       (off),
        .size_i      (size),
        .wdata_i     (wdata),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .err_o       (err),
        .bar_base_o  (bar_base),
        .bar_valid_o (bar_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] o, input logic [2:0] s,
                          input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; off = o; size = s; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        got_rd = rdata; got_err = err; got_ack = ack;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] o, input logic [2:0] s,
                          input logic [31:0] exp);
        access(1'b0, o, s, 32'd0);
        chk(tag, got_rd, exp);
        chk({tag, " err"}, {31'd0, got_err}, 32'd0);
    endtask

    task automatic wr_ok(input string tag, input logic [7:0] o, input logic [2:0] s,
                         input logic [31:0] d);
        access(1'b1, o, s, d);
        chk({tag, " wr err"}, {31'd0, got_err}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R11 ack idle after reset", {31'd0, ack}, 32'd0);
        rd_chk("R1 id word", 8'h00, 3'd4, 32'hBEEF_C0DE);
        rd_chk("R1 class word", 8'h08, 3'd4, 32'h0280_0002);
        rd_chk("R1 status/cmd", 8'h04, 3'd4, 32'h0010_0000);
        rd_chk("R1 tail word", 8'h3C, 3'd4, 32'h0804_010B);
        rd_chk("R1 subsystem", 8'h2C, 3'd4, 32'h2222_1111);
        rd_chk("R1 reserved zero", 8'h34, 3'd4, 32'h0);
        rd_chk("R1 bar1 init", 8'h14, 3'd4, 32'h0000_0001);
        rd_chk("R1 bar5 init", 8'h24, 3'd4, 32'hC000_0000);
        chk("R10 bar5 base at reset", bar_base[5*32 +: 32], 32'hC000_0000);
        chk("R10 valid at reset", {26'd0, bar_valid}, 32'b101000);
    endtask

    task automatic t_packing;
        rd_chk("R1 unaligned half", 8'h01, 3'd2, 32'h0000_EFC0);
        rd_chk("R1 single class byte", 8'h0B, 3'd1, 32'h0000_0002);
        rd_chk("R1 last half", 8'h3E, 3'd2, 32'h0000_0804);
        rd_chk("R1 unaligned word", 8'h0A, 3'd4, 32'h0000_0280);
    endtask

    task automatic t_errors;
        access(1'b0, 8'h40, 3'd1, 32'd0);
        chk("R9 read past header err", {31'd0, got_err}, 32'd1);
        chk("R9 read past header data", got_rd, 32'd0);
        access(1'b0, 8'h3E, 3'd4, 32'd0);
        chk("R9 straddling read err", {31'd0, got_err}, 32'd1);
        chk("R9 straddling read data", got_rd, 32'd0);
        access(1'b0, 8'h00, 3'd3, 32'd0);
        chk("R9 odd width err", {31'd0, got_err}, 32'd1);
        access(1'b1, 8'h00, 3'd1, 32'hFF);
        chk("R9 byte write to vendor err", {31'd0, got_err}, 32'd1);
        rd_chk("R9 vendor unchanged", 8'h00, 3'd2, 32'h0000_C0DE);
        access(1'b1, 8'h08, 3'd2, 32'hFFFF);
        chk("R9 half write to rev err", {31'd0, got_err}, 32'd1);
        access(1'b1, 8'h11, 3'd4, 32'hFFFF_FFFF);
        chk("R9 unaligned slot write err", {31'd0, got_err}, 32'd1);
        rd_chk("R9 bar0 untouched", 8'h10, 3'd4, 32'h0);
        access(1'b1, 8'h28, 3'd4, 32'h1234_5678);
        chk("R9 write to card info err", {31'd0, got_err}, 32'd1);
        rd_chk("R9 card info unchanged", 8'h28, 3'd4, 32'h0);
    endtask

    task automatic t_bar_probe;
        wr_ok("R2 bar0 probe", 8'h10, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 bar0 size mask", 8'h10, 3'd4, 32'hFFFF_F000);
        wr_ok("R2 bar2 probe", 8'h18, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 bar2 size mask keeps type", 8'h18, 3'd4, 32'hFFF0_0008);
        wr_ok("R2 bar4 probe", 8'h20, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 zero-size slot", 8'h20, 3'd4, 32'h0);
        chk("R10 zero-size slot invalid", {31'd0, bar_valid[4]}, 32'd0);
        wr_ok("R2 bar1 probe", 8'h14, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 bar1 io mask", 8'h14, 3'd4, 32'hFFFF_FF01);
    endtask

    task automatic t_bar_types;
        wr_ok("R3 bar0 assign", 8'h10, 3'd4, 32'hE000_0007);
        rd_chk("R3 bar0 type bits held", 8'h10, 3'd4, 32'hE000_0000);
        chk("R10 bar0 base", bar_base[0 +: 32], 32'hE000_0000);
        chk("R10 bar0 valid", {31'd0, bar_valid[0]}, 32'd1);
        wr_ok("R3 bar1 assign", 8'h14, 3'd4, 32'h0000_C003);
        rd_chk("R3 bar1 io type held", 8'h14, 3'd4, 32'h0000_C001);
        chk("R10 bar1 base", bar_base[32 +: 32], 32'h0000_C000);
        wr_ok("R3 bar2 assign", 8'h18, 3'd4, 32'h1234_5670);
        rd_chk("R3 bar2 prefetch held", 8'h18, 3'd4, 32'h1234_5678);
        chk("R10 bar2 base", bar_base[64 +: 32], 32'h1234_5670);
        wr_ok("R3 bar0 low only", 8'h10, 3'd4, 32'h0000_000F);
        rd_chk("R3 bar0 low bits kept zero", 8'h10, 3'd4, 32'h0);
        chk("R10 bar0 invalid at zero", {31'd0, bar_valid[0]}, 32'd0);
    endtask

    task automatic t_legacy;
        wr_ok("R4 legacy probe", 8'h1C, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R4 legacy reads zero", 8'h1C, 3'd4, 32'h0);
        wr_ok("R4 legacy assign", 8'h1C, 3'd4, 32'h8000_0000);
        rd_chk("R4 legacy still zero", 8'h1C, 3'd4, 32'h0);
        chk("R4 legacy base fixed", bar_base[96 +: 32], 32'h0000_03F8);
        chk("R4 legacy valid", {31'd0, bar_valid[3]}, 32'd1);
    endtask

    task automatic t_rom;
        wr_ok("R8 rom probe", 8'h30, 3'd4, 32'hFFFF_FFFE);
        rd_chk("R8 rom probe reads ones", 8'h30, 3'd4, 32'hFFFF_FFFF);
        wr_ok("R8 rom assign", 8'h30, 3'd4, 32'h1234_5601);
        rd_chk("R8 rom stored as is", 8'h30, 3'd4, 32'h1234_5601);
    endtask

    task automatic t_byte_writes;
        wr_ok("R5 iline", 8'h3C, 3'd1, 32'h5A);
        rd_chk("R5 iline read", 8'h3C, 3'd1, 32'h5A);
        wr_ok("R5 cls", 8'h0C, 3'd1, 32'h10);
        wr_ok("R5 lat", 8'h0D, 3'd1, 32'h40);
        rd_chk("R5 cls and lat", 8'h0C, 3'd2, 32'h4010);
        wr_ok("R5 pin ignored", 8'h3D, 3'd1, 32'hFF);
        wr_ok("R5 gnt ignored", 8'h3E, 3'd1, 32'hFF);
        wr_ok("R5 maxlat ignored", 8'h3F, 3'd1, 32'hFF);
        rd_chk("R5 tail unchanged", 8'h3C, 3'd4, 32'h0804_015A);
        wr_ok("R5 rev ignored", 8'h08, 3'd1, 32'hFF);
        rd_chk("R5 rev unchanged", 8'h08, 3'd4, 32'h0280_0002);
    endtask

    task automatic t_half_writes;
        wr_ok("R6 cmd half", 8'h04, 3'd2, 32'h0000_0147);
        wr_ok("R6 status half", 8'h06, 3'd2, 32'h0000_ABCD);
        rd_chk("R6 cmd/status", 8'h04, 3'd4, 32'hABCD_0147);
        wr_ok("R6 cls half", 8'h0C, 3'd2, 32'h0000_7720);
        rd_chk("R6 lat kept", 8'h0C, 3'd2, 32'h0000_4020);
    endtask

    task automatic t_word_cmd;
        wr_ok("R7 cmd word", 8'h04, 3'd4, 32'hFFFF_0006);
        rd_chk("R7 status kept", 8'h04, 3'd4, 32'hABCD_0006);
    endtask

    task automatic t_timing;
        @(negedge clk);
        req = 1'b1; we = 1'b0; off = 8'h00; size = 3'd2;
        chk("R11 no ack in request cycle", {31'd0, ack}, 32'd0);
        @(negedge clk);
        req = 1'b0;
        chk("R11 ack next cycle", {31'd0, ack}, 32'd1);
        chk("R11 data with ack", rdata, 32'h0000_C0DE);
        @(negedge clk);
        chk("R11 ack single cycle", {31'd0, ack}, 32'd0);
        access(1'b1, 8'h3C, 3'd1, 32'h33);
        chk("R11 write acked", {31'd0, got_ack}, 32'd1);
        @(negedge clk);
        chk("R11 write ack single cycle", {31'd0, ack}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packing();
        t_errors();
        t_bar_probe();
        t_bar_types();
        t_legacy();
        t_rom();
        t_byte_writes();
        t_half_writes();
        t_word_cmd();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule